// File: doc/BRIEF.md
# Deterministic Sequence Pattern Generator

This block emits a fixed list of precomputed test vectors back to back, one vector per clock, with no filler vectors in between. The vectors come from a set of small hybrid signature registers. Each stage of a register is either a plain D cell or a toggle cell. Each stage can invert its input or its output, and the inner stages can also take the register's global feedback. A purely combinational steering function drives every parallel input of every register. It looks at where the sequence currently stands and forces each register's next state to be the next vector of the list. The sequence is therefore produced by bending the registers' state diagram, not by reading a stored table through an address counter.

The steering function can learn the current position in one of two ways. It can decode the registers' own outputs against the list, which needs the list entries to be mutually distinct. Or it can read a one-hot position counter. A one-cycle start pulse loads the first vector as the seed. The generator then walks the remaining entries and reports completion. It then keeps the last vector on its outputs until the next start. The vector list, the number of registers the width is split into, the per-stage cell descriptors and the position source are all parameters.

Top module: `dpg_seqgen`

## Requirements
- R1: While reset is high, and afterwards until the first start, `pat_vld` and `seq_done` are 0 and `pat_o` is all zeros.
- R2: When `start` is high at a rising edge, `pat_o` shows list entry 0 and `pat_vld` is 1 immediately after that edge.
- R3: While running without a new start, each rising edge moves `pat_o` to the next list entry. The m entries appear on m consecutive clocks with `pat_vld` high. Consecutive list entries must differ, so `pat_o` changes on every step.
- R4: On the rising edge after the last entry has been shown, `pat_vld` drops, `seq_done` rises, and `pat_o` keeps the last entry.
- R5: Once done, the block holds `seq_done` high and `pat_o` stable for any number of clocks until the next start. `pat_vld` and `seq_done` are never high together.
- R6: A start seen at any time, whether idle, mid-sequence, repeated on consecutive clocks, or after done, restarts the sequence from entry 0.
- R7: The emitted sequence is the same whatever the per-stage descriptors and the register split. Each stage has a 4-bit descriptor: bit 0 selects a toggle cell, bit 1 inverts the cell input, bit 2 adds the global feedback tap (inner stages only), and bit 3 inverts the output. The width is split into k registers, where the last n mod k registers are one bit wider than floor(n/k).
- R8: With the one-hot position counter selected as the steering source, the emitted sequence, valid and done timing are identical to the output-decoding source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all registers |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the seed and starts or restarts the sequence |
| pat_o | output | N_BITS | Current test vector |
| pat_vld | output | 1 | High while a list entry is being presented |
| seq_done | output | 1 | High after the last entry until the next start |

## Verification
The bench drives two generators side by side from the same vector list, which contains all-zero and all-ones entries. One decodes its outputs and uses one register split and one mix of toggle, inverting and tapped stages. The other uses a one-hot counter, a different split and a different stage mix. A plain uninterrupted run shows that the steering equations are right for every cell kind. Idling in done shows the hold. A start mid-run, a start held for several clocks and a start issued while done tell a proper reseed apart from a generator that merely continues or wraps. Every clock is compared against a behavioural list-walking model, so any gap, repeat or early or late done flag is caught at the cycle where it occurs.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    // One stage descriptor; toggle is bit 0, out_inv is bit 3.
    typedef struct packed {
        logic out_inv;
        logic tap_en;
        logic in_inv;
        logic toggle;
    } stage_cfg_t;

    // Width of register r when n bits are split into k registers.
    function automatic int reg_width(int r, int n, int k);
        int narrow = n / k;
        int wide   = n % k;
        return (r >= k - wide) ? narrow + 1 : narrow;
    endfunction

    // Lowest global bit index of register r.
    function automatic int reg_base(int r, int n, int k);
        int acc = 0;
        for (int i = 0; i < r; i++) acc += reg_width(i, n, k);
        return acc;
    endfunction

    // Register holding global bit b.
    function automatic int reg_of(int b, int n, int k);
        int res = 0;
        for (int r = 0; r < k; r++) if (b >= reg_base(r, n, k)) res = r;
        return res;
    endfunction

    // Global index of the stage feeding the serial input of bit b.
    function automatic int serial_src(int b, int n, int k);
        int r  = reg_of(b, n, k);
        int lo = reg_base(r, n, k);
        return (b == lo) ? lo + reg_width(r, n, k) - 1 : b - 1;
    endfunction

    // Global index of the last stage of the register holding bit b.
    function automatic int tap_src(int b, int n, int k);
        int r = reg_of(b, n, k);
        return reg_base(r, n, k) + reg_width(r, n, k) - 1;
    endfunction

    // Taps exist only on inner stages of a register.
    function automatic bit tap_active(bit tap_en, int pos, int w);
        return tap_en && (pos != 0) && (pos != w - 1);
    endfunction

endpackage

// File: rtl/dpg_sigreg.sv
module dpg_sigreg
    import dpg_pkg::*;
#(
    parameter int             W   = 3,
    parameter logic [4*W-1:0] CFG = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    input  logic [W-1:0] pi,
    output logic [W-1:0] po
);

    logic [W-1:0] q;
    logic [W-1:0] q_nxt;
    logic [W-1:0] oinv;

    for (genvar i = 0; i < W; i++) begin : g_stage
        localparam stage_cfg_t C   = CFG[4*i +: 4];
        localparam int         SI  = (i == 0) ? W - 1 : i - 1;
        localparam bit         TAP = tap_active(C.tap_en, i, W);
        logic d_in;
        logic fb;

        if (TAP) begin : g_tap
            assign fb = q[W-1];
        end else begin : g_notap
            assign fb = 1'b0;
        end

        assign d_in     = q[SI] ^ pi[i] ^ fb ^ C.in_inv;
        assign q_nxt[i] = C.toggle ? (q[i] ^ d_in) : d_in;
        assign oinv[i]  = C.out_inv;
        assign po[i]    = q[i] ^ C.out_inv;
    end

    always_ff @(posedge clk) begin
        if (rst)       q <= oinv;
        else if (load) q <= seed ^ oinv;
        else if (step) q <= q_nxt;
    end

endmodule

// File: rtl/dpg_match.sv
module dpg_match #(
    parameter int                        N_BITS   = 8,
    parameter int                        N_PATS   = 6,
    parameter logic [N_PATS*N_BITS-1:0]  PATTERNS = '0
) (
    input  logic [N_BITS-1:0] po,
    output logic [N_PATS-1:0] hit
);

    for (genvar j = 0; j < N_PATS; j++) begin : g_cmp
        assign hit[j] = (po == PATTERNS[j*N_BITS +: N_BITS]);
    end

endmodule

// File: rtl/dpg_modfn.sv
module dpg_modfn
    import dpg_pkg::*;
#(
    parameter int                        N_BITS    = 8,
    parameter int                        N_PATS    = 6,
    parameter int                        N_REGS    = 3,
    parameter logic [N_PATS*N_BITS-1:0]  PATTERNS  = '0,
    parameter logic [4*N_BITS-1:0]       STAGE_CFG = '0
) (
    input  logic [N_BITS-1:0] po,
    input  logic [N_PATS-1:0] sel,
    output logic [N_BITS-1:0] pi
);

    logic [N_BITS-1:0] target;
    logic [N_BITS-1:0] q;

    // Next list entry for the current position; last entry maps to itself.
    always_comb begin
        target = '0;
        for (int j = 0; j < N_PATS; j++) begin
            if (sel[j]) begin
                target |= PATTERNS[((j + 1 < N_PATS) ? j + 1 : j) * N_BITS +: N_BITS];
            end
        end
    end

    for (genvar b = 0; b < N_BITS; b++) begin : g_bit
        localparam stage_cfg_t C   = STAGE_CFG[4*b +: 4];
        localparam int         R   = reg_of(b, N_BITS, N_REGS);
        localparam int         LO  = reg_base(R, N_BITS, N_REGS);
        localparam int         W   = reg_width(R, N_BITS, N_REGS);
        localparam int         SI  = serial_src(b, N_BITS, N_REGS);
        localparam int         TP  = tap_src(b, N_BITS, N_REGS);
        localparam bit         TAP = tap_active(C.tap_en, b - LO, W);
        logic fb;
        logic self_q;

        assign q[b] = po[b] ^ C.out_inv;

        if (TAP) begin : g_tap
            assign fb = q[TP];
        end else begin : g_notap
            assign fb = 1'b0;
        end

        if (C.toggle) begin : g_tgl
            assign self_q = q[b];
        end else begin : g_dff
            assign self_q = 1'b0;
        end

        assign pi[b] = (target[b] ^ C.out_inv) ^ q[SI] ^ fb ^ C.in_inv ^ self_q;
    end

endmodule

// File: rtl/dpg_ctrl.sv
module dpg_ctrl
    import dpg_pkg::*;
#(
    parameter int N_PATS     = 6,
    parameter bit USE_ONEHOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              last_hit,
    output logic              load,
    output logic              step,
    output logic              valid,
    output logic              done,
    output logic [N_PATS-1:0] cnt_oh
);

    seq_state_e st;
    seq_state_e st_nxt;

    always_comb begin
        st_nxt = st;
        load   = 1'b0;
        step   = 1'b0;
        if (start) begin
            load   = 1'b1;
            st_nxt = SEQ_RUN;
        end else if (st == SEQ_RUN) begin
            if (last_hit) st_nxt = SEQ_DONE;
            else          step   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SEQ_IDLE;
        else     st <= st_nxt;
    end

    assign valid = (st == SEQ_RUN);
    assign done  = (st == SEQ_DONE);

    if (USE_ONEHOT) begin : g_onehot
        logic [N_PATS-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)       cnt <= '0;
            else if (load) cnt <= N_PATS'(1);
            else if (step) cnt <= cnt << 1;
        end
        assign cnt_oh = cnt;
    end else begin : g_nocnt
        assign cnt_oh = '0;
    end

endmodule

// File: rtl/dpg_seqgen.sv
module dpg_seqgen
    import dpg_pkg::*;
#(
    parameter int                        N_BITS     = 8,
    parameter int                        N_PATS     = 6,
    parameter int                        N_REGS     = 3,
    parameter bit                        USE_ONEHOT = 1'b0,
    parameter logic [N_PATS*N_BITS-1:0]  PATTERNS   =
        {8'h00, 8'h5A, 8'hFF, 8'h01, 8'hA5, 8'h3C},
    parameter logic [4*N_BITS-1:0]       STAGE_CFG  = 32'h9C3A_51E6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [N_BITS-1:0] pat_o,
    output logic              pat_vld,
    output logic              seq_done
);

    localparam int LAST = N_PATS - 1;

    logic              load;
    logic              step;
    logic              last_hit;
    logic [N_PATS-1:0] cnt_oh;
    logic [N_PATS-1:0] match;
    logic [N_PATS-1:0] sel;
    logic [N_BITS-1:0] po_all;
    logic [N_BITS-1:0] pi_all;

    dpg_ctrl #(.N_PATS(N_PATS), .USE_ONEHOT(USE_ONEHOT)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .last_hit (last_hit),
        .load     (load),
        .step     (step),
        .valid    (pat_vld),
        .done     (seq_done),
        .cnt_oh   (cnt_oh)
    );

    dpg_match #(.N_BITS(N_BITS), .N_PATS(N_PATS), .PATTERNS(PATTERNS)) u_match (
        .po  (po_all),
        .hit (match)
    );

    assign sel      = USE_ONEHOT ? cnt_oh : match;
    assign last_hit = sel[LAST];

    dpg_modfn #(
        .N_BITS    (N_BITS),
        .N_PATS    (N_PATS),
        .N_REGS    (N_REGS),
        .PATTERNS  (PATTERNS),
        .STAGE_CFG (STAGE_CFG)
    ) u_modfn (
        .po  (po_all),
        .sel (sel),
        .pi  (pi_all)
    );

    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        localparam int W  = reg_width(r, N_BITS, N_REGS);
        localparam int LO = reg_base(r, N_BITS, N_REGS);
        dpg_sigreg #(.W(W), .CFG(STAGE_CFG[4*LO +: 4*W])) u_reg (
            .clk  (clk),
            .rst  (rst),
            .load (load),
            .step (step),
            .seed (PATTERNS[LO +: W]),
            .pi   (pi_all[LO +: W]),
            .po   (po_all[LO +: W])
        );
    end

    assign pat_o = po_all;

endmodule

// File: rtl/dpg_seqgen_chk.sv
module dpg_seqgen_chk #(
    parameter int N_BITS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [N_BITS-1:0] pat_o,
    input logic              pat_vld,
    input logic              seq_done
);

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> pat_vld);

    assert_steps_change_R3: assert property (@(posedge clk) disable iff (rst)
        (pat_vld && !start) |=> (seq_done || !$stable(pat_o)));

    assert_end_to_done_R4: assert property (@(posedge clk) disable iff (rst)
        (pat_vld && !start) |=> (pat_vld || seq_done));

    assert_done_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_done && !start) |=> (seq_done && $stable(pat_o)));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(pat_vld && seq_done));

    assert_restart_clears_done_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> !seq_done);

endmodule

bind dpg_seqgen dpg_seqgen_chk #(.N_BITS(N_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pat_o    (pat_o),
    .pat_vld  (pat_vld),
    .seq_done (seq_done)
);

// File: tb/dpg_seqgen_test.sv
module dpg_seqgen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int NP = 6;
    localparam logic [NP*NB-1:0] PATS = {8'h00, 8'h5A, 8'hFF, 8'h01, 8'hA5, 8'h3C};
    localparam int WATCHDOG = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;

    logic [NB-1:0] pat_a, pat_b;
    logic          vld_a, vld_b, done_a, done_b;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    bit armed = 1'b0;
    bit finished = 1'b0;

    // Reference model state: 0 idle, 1 running, 2 done
    int            m_st = 0;
    int            m_idx = 0;
    logic [NB-1:0] m_pat = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // R7: output decoding, 3-way split, mixed stages
    dpg_seqgen #(.N_BITS(NB), .N_PATS(NP), .N_REGS(3), .USE_ONEHOT(1'b0),
                 .PATTERNS(PATS), .STAGE_CFG(32'h9C3A_51E6)) uut (
        .clk(clk), .rst(rst), .start(start),
        .pat_o(pat_a), .pat_vld(vld_a), .seq_done(done_a));

    // R8: one-hot counter, 2-way split, other stage mix
    dpg_seqgen #(.N_BITS(NB), .N_PATS(NP), .N_REGS(2), .USE_ONEHOT(1'b1),
                 .PATTERNS(PATS), .STAGE_CFG(32'h6BD2_0F47)) uut_oh (
        .clk(clk), .rst(rst), .start(start),
        .pat_o(pat_b), .pat_vld(vld_b), .seq_done(done_b));

    always @(posedge clk) begin
        armed <= 1'b1;
        if (rst) begin
            m_st = 0; m_idx = 0; m_pat = '0;
        end else if (start) begin
            m_st = 1; m_idx = 0; m_pat = PATS[0 +: NB];
        end else if (m_st == 1) begin
            if (m_idx == NP - 1) m_st = 2;
            else begin
                m_idx = m_idx + 1;
                m_pat = PATS[m_idx*NB +: NB];
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !finished) begin
            chk({cur_tag, "/R7"}, "uut pattern", 32'(pat_a), 32'(m_pat));
            chk({cur_tag, "/R7"}, "uut valid",   32'(vld_a), 32'(m_st == 1));
            chk({cur_tag, "/R7"}, "uut done",    32'(done_a), 32'(m_st == 2));
            chk({cur_tag, "/R8"}, "uut_oh pattern", 32'(pat_b), 32'(m_pat));
            chk({cur_tag, "/R8"}, "uut_oh valid",   32'(vld_b), 32'(m_st == 1));
            chk({cur_tag, "/R8"}, "uut_oh done",    32'(done_b), 32'(m_st == 2));
        end
    end

    task automatic pulse_start(input int len);
        @(negedge clk) start = 1'b1;
        repeat (len - 1) @(negedge clk);
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cur_tag = "R1";
        wait_cycles(3);
        @(negedge clk) rst = 1'b0;
        wait_cycles(3);

        cur_tag = "R2";
        pulse_start(1);
        cur_tag = "R3";
        wait_cycles(NP - 2);
        cur_tag = "R4";
        wait_cycles(2);
        cur_tag = "R5";
        wait_cycles(6);

        cur_tag = "R6";
        pulse_start(1);
        wait_cycles(2);
        pulse_start(1);
        wait_cycles(3);
        pulse_start(3);
        wait_cycles(NP + 3);

        cur_tag = "R6";
        pulse_start(1);
        cur_tag = "R3";
        wait_cycles(NP + 2);

        cur_tag = "R1";
        @(negedge clk) rst = 1'b1;
        wait_cycles(2);
        @(negedge clk) rst = 1'b0;
        wait_cycles(2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule